// File: doc/BRIEF.md
# Field Compare and Jump Condition Unit

This unit serves a sign-magnitude word machine. A word is one sign position followed by a number of equal-width bytes. The unit holds a three-state comparison indicator. It updates the indicator when a compare instruction names a field of a register and the same field of a memory word. It also decides every conditional transfer of control, using the indicator, the overflow toggle or the contents of a register. For each taken jump it gives the target address, the return-address write for the J register and the request to clear the overflow toggle.

An instruction is presented for one cycle with `op_valid` high. All results appear on registered outputs one clock edge later. The jump outputs are one-cycle pulses. The indicator keeps its value until the next compare. The field specifier is the modifier byte read as 8L+R, where L (bits 5:3) and R (bits 2:0) select positions 0 to 5. Position 0 is the sign and positions 1 to 5 are the bytes, counted from the most significant one.

Top module: `fcj_unit`

## Requirements
- R1: `cmp_ind` only takes the values EQUAL=2'b00, LESS=2'b01 and GREATER=2'b10. It is EQUAL after reset. It takes a new value one edge after a valid compare (opcode 56 to 63) and holds its value at all other times.
- R2: When L=0, the selected bytes form a magnitude that carries the word's sign, and the register operand is compared with the memory operand as a signed value.
- R3: When L>0, only bytes L through R of each word take part, and both operands are compared as nonnegative values whatever their signs.
- R4: A zero magnitude is equal to zero whatever its sign. A sign-only field (0:0) therefore always gives EQUAL.
- R5: Opcode 39 with modifier 0 always jumps. A taken jump pulses `jump_taken` for one cycle, with `jump_target` equal to the instruction address input.
- R6: Opcode 39 jumps on the indicator as follows: modifier 4 on LESS, 5 on EQUAL, 6 on GREATER, 7 on not LESS, 8 on not EQUAL, 9 on not GREATER.
- R7: Opcode 39 with modifier 2 jumps when the overflow toggle is set, and with modifier 3 when it is clear. Both pulse `ovf_clr`, whether the jump is taken or not.
- R8: Every taken jump pulses `j_we` with `j_value` equal to the program counter plus one. The one exception is opcode 39 with modifier 1, which jumps without writing J.
- R9: Opcodes 40 to 47 test the register word. Modifier 0 jumps if it is negative, 1 if zero, 2 if positive, 3 if nonnegative, 4 if nonzero and 5 if nonpositive. A minus-zero word counts as zero.
- R10: Other opcodes, other modifiers of the jump opcodes, and cycles with `op_valid` low produce no jump, no J write and no overflow clear, and leave the indicator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction present this cycle |
| opcode | input | 6 | Operation code |
| modifier | input | 6 | Field specifier or jump variant |
| reg_word | input | 31 | Register operand (sign is the MSB) |
| mem_word | input | 31 | Memory operand (sign is the MSB) |
| ovf_in | input | 1 | Current overflow toggle |
| addr_in | input | 12 | Effective address of the instruction |
| pc_in | input | 12 | Address of the current instruction |
| cmp_ind | output | 2 | Comparison indicator |
| jump_taken | output | 1 | Jump-taken pulse |
| jump_target | output | 12 | Target of the taken jump |
| j_we | output | 1 | J register write pulse |
| j_value | output | 12 | Return address to write into J |
| ovf_clr | output | 1 | Overflow toggle clear pulse |

## Verification
The bench checks a negative register against a positive memory word twice: once with the whole word, where it must read LESS, and once over (1:5), where it must read GREATER. A design that ignored L would give LESS both times. Minus zero is applied to both compare operands, to a sign-only field and to the register tests. A design that read the sign bit alone would report LESS or take the jump on negative. The bench also tests the jump on no overflow with the toggle clear and the jump that leaves J alone, and it drives compare data while `op_valid` is low. These expose a missing clear, a stray J write and an indicator that is not held.

// File: rtl/fcj_pkg.sv
package fcj_pkg;
    typedef enum logic [1:0] {
        CI_EQUAL   = 2'b00,
        CI_LESS    = 2'b01,
        CI_GREATER = 2'b10
    } cmp_ind_e;

    localparam logic [5:0] OP_JUMP     = 6'd39;
    localparam logic [5:0] OP_RTEST_LO = 6'd40;
    localparam logic [5:0] OP_RTEST_HI = 6'd47;
    localparam logic [5:0] OP_CMP_LO   = 6'd56;
    localparam logic [5:0] OP_CMP_HI   = 6'd63;
endpackage

// File: rtl/fcj_field_cmp.sv
module fcj_field_cmp
    import fcj_pkg::*;
#(
    parameter int BYTE_W = 6,
    parameter int NBYTES = 5,
    localparam int MAG_W = BYTE_W * NBYTES,
    localparam int WORD_W = MAG_W + 1
) (
    input  logic [WORD_W-1:0] lhs_word,
    input  logic [WORD_W-1:0] rhs_word,
    input  logic [2:0]        fld_l,
    input  logic [2:0]        fld_r,
    output cmp_ind_e          result
);
    logic [MAG_W-1:0] lhs_mag, rhs_mag;
    logic signed [MAG_W:0] lhs_val, rhs_val;
    logic use_sign;

    for (genvar k = 1; k <= NBYTES; k++) begin : g_byte
        localparam int LSB = (NBYTES - k) * BYTE_W;
        logic sel;
        assign sel = (3'(k) >= fld_l) && (3'(k) <= fld_r);
        assign lhs_mag[LSB +: BYTE_W] = sel ? lhs_word[LSB +: BYTE_W] : '0;
        assign rhs_mag[LSB +: BYTE_W] = sel ? rhs_word[LSB +: BYTE_W] : '0;
    end

    assign use_sign = (fld_l == 3'd0);

    always_comb begin
        lhs_val = $signed({1'b0, lhs_mag});
        rhs_val = $signed({1'b0, rhs_mag});
        if (use_sign && lhs_word[WORD_W-1]) lhs_val = -lhs_val;
        if (use_sign && rhs_word[WORD_W-1]) rhs_val = -rhs_val;
        if (lhs_val < rhs_val)      result = CI_LESS;
        else if (lhs_val > rhs_val) result = CI_GREATER;
        else                        result = CI_EQUAL;
    end

    // r4: equal magnitudes with no sign involvement must read EQUAL
    always_comb begin
        if (!use_sign && lhs_mag == rhs_mag)
            a_r4_mag_equal: assert (result == CI_EQUAL);
    end
endmodule

// File: rtl/fcj_jump_eval.sv
module fcj_jump_eval
    import fcj_pkg::*;
#(
    parameter int WORD_W = 31
) (
    input  logic [5:0]        opcode,
    input  logic [5:0]        modifier,
    input  cmp_ind_e          cmp_ind,
    input  logic              ovf,
    input  logic [WORD_W-1:0] reg_word,
    output logic              take,
    output logic              save_j,
    output logic              clr_ovf
);
    logic is_zero, is_neg, is_pos;

    assign is_zero = (reg_word[WORD_W-2:0] == '0);
    assign is_neg  = reg_word[WORD_W-1] && !is_zero;
    assign is_pos  = !reg_word[WORD_W-1] && !is_zero;

    always_comb begin
        take    = 1'b0;
        save_j  = 1'b0;
        clr_ovf = 1'b0;
        if (opcode == OP_JUMP) begin
            case (modifier)
                6'd0: take = 1'b1;
                6'd1: take = 1'b1;
                6'd2: begin take = ovf;  clr_ovf = 1'b1; end
                6'd3: begin take = !ovf; clr_ovf = 1'b1; end
                6'd4: take = (cmp_ind == CI_LESS);
                6'd5: take = (cmp_ind == CI_EQUAL);
                6'd6: take = (cmp_ind == CI_GREATER);
                6'd7: take = (cmp_ind != CI_LESS);
                6'd8: take = (cmp_ind != CI_EQUAL);
                6'd9: take = (cmp_ind != CI_GREATER);
                default: take = 1'b0;
            endcase
            save_j = take && (modifier != 6'd1);
        end else if (opcode >= OP_RTEST_LO && opcode <= OP_RTEST_HI) begin
            case (modifier)
                6'd0: take = is_neg;
                6'd1: take = is_zero;
                6'd2: take = is_pos;
                6'd3: take = !is_neg;
                6'd4: take = !is_zero;
                6'd5: take = !is_pos;
                default: take = 1'b0;
            endcase
            save_j = take;
        end
    end
endmodule

// File: rtl/fcj_unit.sv
module fcj_unit
    import fcj_pkg::*;
#(
    parameter int BYTE_W = 6,
    parameter int NBYTES = 5,
    parameter int ADDR_W = 12,
    localparam int WORD_W = BYTE_W * NBYTES + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [5:0]        opcode,
    input  logic [5:0]        modifier,
    input  logic [WORD_W-1:0] reg_word,
    input  logic [WORD_W-1:0] mem_word,
    input  logic              ovf_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [ADDR_W-1:0] pc_in,
    output logic [1:0]        cmp_ind,
    output logic              jump_taken,
    output logic [ADDR_W-1:0] jump_target,
    output logic              j_we,
    output logic [ADDR_W-1:0] j_value,
    output logic              ovf_clr
);
    typedef struct packed {
        cmp_ind_e          ind;
        logic              taken;
        logic [ADDR_W-1:0] target;
        logic              jwe;
        logic [ADDR_W-1:0] jval;
        logic              clr;
    } state_t;

    state_t st_d, st_q;
    cmp_ind_e cmp_res;
    logic take, save_j, clr_ovf, is_cmp;

    fcj_field_cmp #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) cmp_i (
        .lhs_word (reg_word),
        .rhs_word (mem_word),
        .fld_l    (modifier[5:3]),
        .fld_r    (modifier[2:0]),
        .result   (cmp_res)
    );

    fcj_jump_eval #(.WORD_W(WORD_W)) jmp_i (
        .opcode   (opcode),
        .modifier (modifier),
        .cmp_ind  (st_q.ind),
        .ovf      (ovf_in),
        .reg_word (reg_word),
        .take     (take),
        .save_j   (save_j),
        .clr_ovf  (clr_ovf)
    );

    assign is_cmp = (opcode >= OP_CMP_LO) && (opcode <= OP_CMP_HI);

    always_comb begin
        st_d        = st_q;
        st_d.taken  = 1'b0;
        st_d.jwe    = 1'b0;
        st_d.clr    = 1'b0;
        if (op_valid) begin
            if (is_cmp) st_d.ind = cmp_res;
            st_d.taken  = take;
            st_d.target = addr_in;
            st_d.jwe    = save_j;
            st_d.jval   = pc_in + ADDR_W'(1);
            st_d.clr    = clr_ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ind: CI_EQUAL, taken: 1'b0, target: '0,
                      jwe: 1'b0, jval: '0, clr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_ind     = st_q.ind;
    assign jump_taken  = st_q.taken;
    assign jump_target = st_q.target;
    assign j_we        = st_q.jwe;
    assign j_value     = st_q.jval;
    assign ovf_clr     = st_q.clr;

    a_r1_ind_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_ind != 2'b11);
    a_r1_ind_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && is_cmp) |=> $stable(cmp_ind));
    a_r7_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_JUMP && (modifier == 6'd2 || modifier == 6'd3)) |=> ovf_clr);
    a_r8_no_save: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_JUMP && modifier == 6'd1) |=> (jump_taken && !j_we));
    a_r8_return_addr: assert property (@(posedge clk) disable iff (!rst_n)
        j_we |-> (jump_taken && j_value == $past(pc_in) + ADDR_W'(1)));
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!jump_taken && !j_we && !ovf_clr));
endmodule

// File: tb/fcj_unit_tb_top.sv
module fcj_unit_tb_top;
    localparam int AW = 12;
    localparam logic [1:0] EQ = 2'b00, LT = 2'b01, GT = 2'b10;

    typedef struct packed {
        logic [5:0]  opc;
        logic [5:0]  mdf;
        logic [30:0] rv;
        logic [30:0] mv;
        logic        ovf;
        logic [1:0]  e_ind;
        logic        e_tk;
        logic        e_jwe;
        logic        e_clr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [0:NV-1] = '{
        '{6'd56, 6'd5,  {1'b0,30'd5}, {1'b0,30'd7}, 1'b0, LT, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{6'd56, 6'd5,  {1'b1,30'd5}, {1'b0,30'd3}, 1'b0, LT, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{6'd56, 6'd5,  {1'b1,30'd0}, {1'b0,30'd0}, 1'b0, EQ, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{6'd39, 6'd7,  31'd0,        31'd0,        1'b0, EQ, 1'b1, 1'b1, 1'b0, 4'd6},  // R6
        '{6'd56, 6'd13, {1'b1,30'd5}, {1'b0,30'd3}, 1'b0, GT, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
        '{6'd39, 6'd4,  31'd0,        31'd0,        1'b0, GT, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
        '{6'd56, 6'd5,  {1'b0,30'd9}, {1'b1,30'd9}, 1'b0, GT, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{6'd57, 6'd27, {1'b1,6'd1,6'd2,6'd7,6'd4,6'd5},
                        {1'b0,6'd9,6'd9,6'd7,6'd0,6'd0}, 1'b0, EQ, 1'b0, 1'b0, 1'b0, 4'd3}, // R3
        '{6'd39, 6'd5,  31'd0,        31'd0,        1'b0, EQ, 1'b1, 1'b1, 1'b0, 4'd6},  // R6
        '{6'd56, 6'd0,  {1'b1,30'd5}, {1'b0,30'd9}, 1'b0, EQ, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{6'd39, 6'd0,  31'd0,        31'd0,        1'b0, EQ, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
        '{6'd39, 6'd1,  31'd0,        31'd0,        1'b0, EQ, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
        '{6'd39, 6'd2,  31'd0,        31'd0,        1'b1, EQ, 1'b1, 1'b1, 1'b1, 4'd7},  // R7
        '{6'd39, 6'd2,  31'd0,        31'd0,        1'b0, EQ, 1'b0, 1'b0, 1'b1, 4'd7},  // R7
        '{6'd39, 6'd3,  31'd0,        31'd0,        1'b0, EQ, 1'b1, 1'b1, 1'b1, 4'd7},  // R7
        '{6'd40, 6'd0,  {1'b1,30'd5}, 31'd0,        1'b0, EQ, 1'b1, 1'b1, 1'b0, 4'd9},  // R9
        '{6'd40, 6'd0,  {1'b1,30'd0}, 31'd0,        1'b0, EQ, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
        '{6'd47, 6'd1,  {1'b1,30'd0}, 31'd0,        1'b0, EQ, 1'b1, 1'b1, 1'b0, 4'd9},  // R9
        '{6'd8,  6'd5,  {1'b0,30'd1}, {1'b0,30'd9}, 1'b1, EQ, 1'b0, 1'b0, 1'b0, 4'd10}  // R10
    };

    logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0, ovf_in = 1'b0;
    logic [5:0] opcode = '0, modifier = '0;
    logic [30:0] reg_word = '0, mem_word = '0;
    logic [AW-1:0] addr_in = '0, pc_in = '0;
    logic [1:0] cmp_ind;
    logic jump_taken, j_we, ovf_clr;
    logic [AW-1:0] jump_target, j_value;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fcj_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .modifier(modifier), .reg_word(reg_word), .mem_word(mem_word),
        .ovf_in(ovf_in), .addr_in(addr_in), .pc_in(pc_in),
        .cmp_ind(cmp_ind), .jump_taken(jump_taken), .jump_target(jump_target),
        .j_we(j_we), .j_value(j_value), .ovf_clr(ovf_clr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [5:0] opc, input logic [5:0] mdf, input logic [30:0] rv,
                         input logic [30:0] mv, input logic ov, input logic vld);
        @(negedge clk);
        opcode = opc; modifier = mdf; reg_word = rv; mem_word = mv; ovf_in = ov;
        op_valid = vld;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R1)
        chk("R1", "reset ind", 32'(cmp_ind), 32'(EQ));
        chk("R1", "reset taken", 32'(jump_taken), 0);
        chk("R10", "reset jwe/clr", 32'({j_we, ovf_clr}), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", TBL[i].req);
            addr_in = AW'(500 + i);
            pc_in = AW'(100 + i);
            issue(TBL[i].opc, TBL[i].mdf, TBL[i].rv, TBL[i].mv, TBL[i].ovf, 1'b1);
            chk(tag, $sformatf("row %0d ind", i), 32'(cmp_ind), 32'(TBL[i].e_ind));
            chk(tag, $sformatf("row %0d taken", i), 32'(jump_taken), 32'(TBL[i].e_tk));
            chk(tag, $sformatf("row %0d jwe", i), 32'(j_we), 32'(TBL[i].e_jwe));
            chk(tag, $sformatf("row %0d clr", i), 32'(ovf_clr), 32'(TBL[i].e_clr));
            if (TBL[i].e_tk)
                chk("R5", $sformatf("row %0d target", i), 32'(jump_target), 500 + i);
            if (TBL[i].e_jwe)
                chk("R8", $sformatf("row %0d jval", i), 32'(j_value), 101 + i);
        end

        // R10: compare data with op_valid low leaves indicator EQUAL
        issue(6'd56, 6'd5, {1'b0,30'd1}, {1'b0,30'd2}, 1'b1, 1'b0);
        chk("R10", "idle ind", 32'(cmp_ind), 32'(EQ));
        chk("R10", "idle pulses", 32'({jump_taken, j_we, ovf_clr}), 0);
        // R1: indicator holds across a jump, then pulses drop after one cycle
        issue(6'd60, 6'd5, {1'b0,30'd1}, {1'b0,30'd2}, 1'b0, 1'b1);
        chk("R1", "new LESS", 32'(cmp_ind), 32'(LT));
        issue(6'd39, 6'd4, '0, '0, 1'b0, 1'b1);
        chk("R6", "JL on LESS", 32'(jump_taken), 1);
        @(negedge clk);
        chk("R5", "pulse drops", 32'(jump_taken), 0);
        chk("R1", "ind held", 32'(cmp_ind), 32'(LT));
        // R9: positive test on +3, R10: unknown modifier
        issue(6'd41, 6'd2, {1'b0,30'd3}, '0, 1'b0, 1'b1);
        chk("R9", "pos test", 32'(jump_taken), 1);
        issue(6'd39, 6'd12, '0, '0, 1'b1, 1'b1);
        chk("R10", "bad modifier", 32'({jump_taken, j_we, ovf_clr}), 0);
        // R3: partial field (2:4) GREATER despite signs
        issue(6'd63, 6'd20, {1'b1,6'd0,6'd5,6'd0,6'd0,6'd0},
              {1'b0,6'd9,6'd4,6'd9,6'd9,6'd9}, 1'b0, 1'b1);
        chk("R3", "field 2:4", 32'(cmp_ind), 32'(GT));
        // R1: reset returns to EQUAL
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "re-reset ind", 32'(cmp_ind), 32'(EQ));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule